// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is a serial slave port. It gives an external bus master read and write access to a small register file that sits next to it. The master drives a clock line and a data line. The block watches both lines with its own system clock: each line passes through a two-stage synchroniser, and clock edges, start conditions and stop conditions are found in the system clock domain. The block answers only to its own 7-bit device address, which is set by a parameter. It acknowledges each byte it accepts by pulling the data line low for the ninth clock.

A transaction opens with a start condition. The master then sends the device address with a read/write bit. In a write, the next byte loads an internal register pointer, and every byte after that is written to the register the pointer selects. The pointer then moves to the next register. In a read, the block shifts out the register at the pointer, most significant bit first, and moves the pointer after each byte. It keeps sending bytes until the master answers a byte with a not-acknowledge. The usual way to read is to write the register address, issue a repeated start, and then send the address again with the read bit set.

A mode input chooses between two wiring options. In the shared-line option, the block pulls the one bidirectional data line low. In the separate-pin option, the data line is an input only, and every acknowledge and read bit goes out on its own open-drain data-out pin.

Top module: `regport_slave`

## Requirements
- R1: After reset both pull-down outputs are inactive and no register access is issued. Clock pulses with no preceding start condition (for example after a stop) draw no acknowledge and no register write.
- R2: When the first byte after a start carries the matching device address, the block holds the data line low for the whole high period of the ninth clock. The address is bits 7:1, sent MSB first, and bit 0 is the read/write flag (0 = write, 1 = read).
- R3: When the address does not match, no acknowledge is given and no register write follows. This lasts until the next start condition.
- R4: In a write, the byte after the address loads the register pointer. The next data byte produces exactly one write strobe, with that byte on the write-data output and the pointer on the register address output. Each of these bytes is acknowledged.
- R5: Further data bytes in the same write go to consecutive registers, because the pointer moves up by one after each byte.
- R6: In a read, the byte at the pointer is shifted out MSB first on the data line, with a pull-down for each 0 bit. The pointer moves up by one after each byte sent. The next byte follows while the master acknowledges, and the pointer stays where it is for later transactions.
- R7: A not-acknowledge from the master after a read byte ends the output. The data line then stays released until the next start or stop.
- R8: A repeated start, including one in the middle of a byte, clears the bit count and starts address matching again without a stop.
- R9: When the mode input is high, every acknowledge and read bit is driven on the data-out pin, and the shared data line is never pulled. When the mode input is low, the data-out pin is never driven.
- R10: The register pointer is 8 bits wide and wraps from 0xFF to 0x00 during a multi-byte write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| three_wire | input | 1 | 1 = drive output on the separate data-out pin, 0 = pull the shared data line |
| scl_i | input | 1 | Serial clock from the master, asynchronous |
| sda_i | input | 1 | Data line (shared line, or data-in pin in separate-pin mode), asynchronous |
| sda_pull_o | output | 1 | Pull-down enable for the shared data line |
| dout_pull_o | output | 1 | Pull-down enable for the separate data-out pin |
| reg_addr_o | output | 8 | Register pointer presented to the register file |
| reg_wr_en_o | output | 1 | One-cycle write strobe |
| reg_wr_data_o | output | 8 | Data to write |
| reg_rd_en_o | output | 1 | One-cycle strobe when a read byte is fetched |
| reg_rd_data_i | input | 8 | Register file contents at reg_addr_o, combinational |

## Verification
The bench sweeps all 128 device addresses in both wiring modes. A wrong compare would acknowledge a stranger or miss its own address. A full transaction to a foreign address checks that a design which only suppresses the first acknowledge still writes nothing. The bench reads back across a repeated start and stops the read with a not-acknowledge. An off-by-one pointer step would return shifted data, and a design that ignored the not-acknowledge would pull the line in the next clocks. A repeated start after three stray bits, followed by a write across register 0xFF, exposes a bit count that is not cleared and a pointer that does not wrap. Both pull-down pins are watched on every cycle for a drive in the wrong mode.

// File: rtl/regport_pkg.sv
package regport_pkg;

    localparam int BYTE_W  = 8;
    localparam int DEVA_W  = 7;
    localparam int BITCNT_W = 4;
    localparam logic [BITCNT_W-1:0] LAST_DATA_BIT = BITCNT_W'(BYTE_W);
    localparam logic [BITCNT_W-1:0] ACK_BIT       = BITCNT_W'(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_REGADDR,
        ST_WRITE,
        ST_READ,
        ST_IGNORE
    } eng_state_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } line_ev_t;

    function automatic logic dev_hit(input logic [BYTE_W-1:0] frame,
                                     input logic [DEVA_W-1:0] own);
        return frame[BYTE_W-1:1] == own;
    endfunction

    function automatic logic is_receiving(input eng_state_t s);
        return (s == ST_DEVADDR) || (s == ST_REGADDR) || (s == ST_WRITE);
    endfunction

endpackage

// File: rtl/regport_linesync.sv
module regport_linesync
    import regport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_raw,
    input  logic     sda_raw,
    output line_ev_t ev
);

    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] scl_chain;
    logic [CHAIN-1:0] sda_chain;

    genvar g;
    generate
        for (g = 0; g < CHAIN; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) begin
                        scl_chain[0] <= 1'b1;
                        sda_chain[0] <= 1'b1;
                    end else begin
                        scl_chain[0] <= scl_raw;
                        sda_chain[0] <= sda_raw;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) begin
                        scl_chain[g] <= 1'b1;
                        sda_chain[g] <= 1'b1;
                    end else begin
                        scl_chain[g] <= scl_chain[g-1];
                        sda_chain[g] <= sda_chain[g-1];
                    end
                end
            end
        end
    endgenerate

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_chain[SYNC_STAGES-1];
    assign scl_old = scl_chain[SYNC_STAGES];
    assign sda_now = sda_chain[SYNC_STAGES-1];
    assign sda_old = sda_chain[SYNC_STAGES];

    always_comb begin
        ev.scl_rise = scl_now & ~scl_old;
        ev.scl_fall = ~scl_now & scl_old;
        ev.start    = scl_now & scl_old & sda_old & ~sda_now;
        ev.stop     = scl_now & scl_old & ~sda_old & sda_now;
        ev.sda      = sda_now;
    end

endmodule

// File: rtl/regport_engine.sv
module regport_engine
    import regport_pkg::*;
#(
    parameter logic [DEVA_W-1:0] DEV_ADDR = 7'h2A,
    parameter int                PTR_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              pull_req,
    output logic [PTR_W-1:0]  ptr,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_en
);

    eng_state_t            st;
    logic [BITCNT_W-1:0]   bitcnt;
    logic [BYTE_W-1:0]     shreg;
    logic                  rw_flag;
    logic                  master_nack;

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            bitcnt      <= '0;
            shreg       <= '0;
            rw_flag     <= 1'b0;
            master_nack <= 1'b0;
            pull_req    <= 1'b0;
            ptr         <= '0;
            wr_en       <= 1'b0;
            wr_data     <= '0;
            rd_en       <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            rd_en <= 1'b0;
            if (ev.start) begin
                st       <= ST_DEVADDR;
                bitcnt   <= '0;
                pull_req <= 1'b0;
            end else if (ev.stop) begin
                st       <= ST_IDLE;
                bitcnt   <= '0;
                pull_req <= 1'b0;
            end else if (ev.scl_rise) begin
                if (is_receiving(st)) begin
                    if (bitcnt < LAST_DATA_BIT)
                        shreg <= {shreg[BYTE_W-2:0], ev.sda};
                    if (bitcnt != ACK_BIT)
                        bitcnt <= bitcnt + 1'b1;
                end else if (st == ST_READ) begin
                    if (bitcnt == LAST_DATA_BIT)
                        master_nack <= ev.sda;
                    if (bitcnt != ACK_BIT)
                        bitcnt <= bitcnt + 1'b1;
                end
            end else if (ev.scl_fall) begin
                case (st)
                    ST_DEVADDR: begin
                        if (bitcnt == LAST_DATA_BIT) begin
                            if (dev_hit(shreg, DEV_ADDR)) begin
                                pull_req <= 1'b1;
                                rw_flag  <= shreg[0];
                            end else begin
                                st <= ST_IGNORE;
                            end
                        end else if (bitcnt == ACK_BIT) begin
                            pull_req <= 1'b0;
                            bitcnt   <= '0;
                            if (rw_flag) begin
                                st       <= ST_READ;
                                shreg    <= rd_data;
                                pull_req <= ~rd_data[BYTE_W-1];
                                rd_en    <= 1'b1;
                            end else begin
                                st <= ST_REGADDR;
                            end
                        end
                    end
                    ST_REGADDR: begin
                        if (bitcnt == LAST_DATA_BIT) begin
                            ptr      <= PTR_W'(shreg);
                            pull_req <= 1'b1;
                        end else if (bitcnt == ACK_BIT) begin
                            pull_req <= 1'b0;
                            bitcnt   <= '0;
                            st       <= ST_WRITE;
                        end
                    end
                    ST_WRITE: begin
                        if (bitcnt == LAST_DATA_BIT) begin
                            wr_en    <= 1'b1;
                            wr_data  <= shreg;
                            pull_req <= 1'b1;
                        end else if (bitcnt == ACK_BIT) begin
                            pull_req <= 1'b0;
                            bitcnt   <= '0;
                            ptr      <= ptr + 1'b1;
                        end
                    end
                    ST_READ: begin
                        if (bitcnt == LAST_DATA_BIT) begin
                            pull_req <= 1'b0;
                            ptr      <= ptr + 1'b1;
                        end else if (bitcnt == ACK_BIT) begin
                            bitcnt <= '0;
                            if (master_nack) begin
                                st       <= ST_IGNORE;
                                pull_req <= 1'b0;
                            end else begin
                                shreg    <= rd_data;
                                pull_req <= ~rd_data[BYTE_W-1];
                                rd_en    <= 1'b1;
                            end
                        end else if (bitcnt != '0) begin
                            shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                            pull_req <= ~shreg[BYTE_W-2];
                        end
                    end
                    default: begin
                        pull_req <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/regport_drive.sv
module regport_drive (
    input  logic clk,
    input  logic rst,
    input  logic three_wire,
    input  logic pull_req,
    output logic sda_pull,
    output logic dout_pull
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sda_pull  <= 1'b0;
            dout_pull <= 1'b0;
        end else begin
            sda_pull  <= pull_req & ~three_wire;
            dout_pull <= pull_req & three_wire;
        end
    end

endmodule

// File: rtl/regport_slave.sv
module regport_slave
    import regport_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h2A,
    parameter int         PTR_W       = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             three_wire,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_pull_o,
    output logic             dout_pull_o,
    output logic [PTR_W-1:0] reg_addr_o,
    output logic             reg_wr_en_o,
    output logic [7:0]       reg_wr_data_o,
    output logic             reg_rd_en_o,
    input  logic [7:0]       reg_rd_data_i
);

    line_ev_t ev;
    logic     pull_req;

    regport_linesync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_raw (scl_i),
        .sda_raw (sda_i),
        .ev      (ev)
    );

    regport_engine #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .rd_data  (reg_rd_data_i),
        .pull_req (pull_req),
        .ptr      (reg_addr_o),
        .wr_en    (reg_wr_en_o),
        .wr_data  (reg_wr_data_o),
        .rd_en    (reg_rd_en_o)
    );

    regport_drive u_drv (
        .clk        (clk),
        .rst        (rst),
        .three_wire (three_wire),
        .pull_req   (pull_req),
        .sda_pull   (sda_pull_o),
        .dout_pull  (dout_pull_o)
    );

endmodule

// File: rtl/regport_checks.sv
module regport_checks (
    input logic clk,
    input logic rst,
    input logic three_wire,
    input logic scl_i,
    input logic sda_pull_o,
    input logic dout_pull_o,
    input logic reg_wr_en_o,
    input logic reg_rd_en_o
);

    a_r9_shared_quiet: assert property (@(posedge clk) disable iff (rst)
        three_wire |-> !sda_pull_o);

    a_r9_dout_quiet: assert property (@(posedge clk) disable iff (rst)
        !three_wire |-> !dout_pull_o);

    a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en_o |=> !reg_wr_en_o);

    a_r6_no_rw_overlap: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr_en_o && reg_rd_en_o));

    a_r2_drive_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull_o | dout_pull_o) |-> !scl_i);

endmodule

bind regport_slave regport_checks u_checks (
    .clk         (clk),
    .rst         (rst),
    .three_wire  (three_wire),
    .scl_i       (scl_i),
    .sda_pull_o  (sda_pull_o),
    .dout_pull_o (dout_pull_o),
    .reg_wr_en_o (reg_wr_en_o),
    .reg_rd_en_o (reg_rd_en_o)
);

// File: tb/tb_regport_slave.sv
module tb_regport_slave;

    localparam logic [6:0] DEV = 7'h2A;
    localparam int Q = 6;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst = 1'b1;
    logic       three_wire = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_pull, dout_pull;
    logic [7:0] reg_addr, wr_data, rd_data;
    logic       wr_en, rd_en;
    logic       sda_w, s_line;

    logic [7:0] regs [256];
    logic [7:0] exp_mem [256];
    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int wrong_pin = 0;
    int right_pin = 0;

    assign sda_w   = three_wire ? m_sda : (m_sda & ~sda_pull);
    assign s_line  = three_wire ? (m_sda & ~dout_pull) : (m_sda & ~sda_pull);
    assign rd_data = regs[reg_addr];

    regport_slave #(.DEV_ADDR(DEV)) dut (
        .clk           (clk),
        .rst           (rst),
        .three_wire    (three_wire),
        .scl_i         (m_scl),
        .sda_i         (sda_w),
        .sda_pull_o    (sda_pull),
        .dout_pull_o   (dout_pull),
        .reg_addr_o    (reg_addr),
        .reg_wr_en_o   (wr_en),
        .reg_wr_data_o (wr_data),
        .reg_rd_en_o   (rd_en),
        .reg_rd_data_i (rd_data)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) regs[i] <= init_val(i);
        end else begin
            if (wr_en) begin
                regs[reg_addr] <= wr_data;
                wr_cnt <= wr_cnt + 1;
            end
            if ((three_wire && sda_pull) || (!three_wire && dout_pull))
                wrong_pin <= wrong_pin + 1;
            if ((three_wire && dout_pull) || (!three_wire && sda_pull))
                right_pin <= right_pin + 1;
        end
    end

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        rst = 1'b1;
        three_wire = mode;
        m_scl = 1'b1;
        m_sda = 1'b1;
        for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
        waitc(5);
        rst = 1'b0;
        waitc(5);
    endtask

    task automatic start_cond();
        m_sda = 1'b1; waitc(Q);
        m_scl = 1'b1; waitc(2*Q);
        m_sda = 1'b0; waitc(2*Q);
        m_scl = 1'b0; waitc(Q);
    endtask

    task automatic stop_cond();
        m_sda = 1'b0; waitc(Q);
        m_scl = 1'b1; waitc(2*Q);
        m_sda = 1'b1; waitc(2*Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;    waitc(Q);
        m_scl = 1'b1; waitc(2*Q);
        m_scl = 1'b0; waitc(Q);
    endtask

    // returns the line value; held is 1 when it stayed the same through the high phase
    task automatic recv_bit(output logic b, output logic held);
        logic early;
        m_sda = 1'b1; waitc(Q);
        m_scl = 1'b1; waitc(1);
        early = s_line;
        waitc(2*Q - 2);
        b = s_line;
        held = (early == b);
        waitc(1);
        m_scl = 1'b0; waitc(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic b, h;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b, h);
        acked = (b == 1'b0) && h;
    endtask

    task automatic recv_byte(input logic master_ack, output logic [7:0] v);
        logic b, h;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b, h);
            v[i] = b;
        end
        send_bit(~master_ack);
    endtask

    task automatic run_mode(input logic mode);
        logic       ack;
        logic [7:0] v;
        logic       b, h;
        int         w0;

        do_reset(mode);
        // R1: reset state
        chk(!sda_pull && !dout_pull, "R1 reset pulls", {sda_pull, dout_pull}, 0);
        chk(!wr_en && !rd_en, "R1 reset strobes", {wr_en, rd_en}, 0);

        // R2 / R3: sweep every device address
        for (int a = 0; a < 128; a++) begin
            start_cond();
            send_byte({7'(a), 1'b0}, ack);
            stop_cond();
            chk(ack == (a == int'(DEV)), (a == int'(DEV)) ? "R2 own address ack" : "R3 foreign address nack",
                ack, a == int'(DEV));
        end

        // R4 / R5: write three bytes from 0x10
        start_cond();
        send_byte({DEV, 1'b0}, ack); chk(ack, "R2 address ack", ack, 1);
        send_byte(8'h10, ack);       chk(ack, "R4 pointer byte ack", ack, 1);
        for (int i = 0; i < 3; i++) begin
            v = 8'hA5 ^ 8'(i * 29) ^ {7'd0, mode};
            send_byte(v, ack);
            chk(ack, "R5 data byte ack", ack, 1);
            exp_mem[8'h10 + i] = v;
        end
        stop_cond();
        for (int i = 0; i < 3; i++)
            chk(regs[8'h10 + i] == exp_mem[8'h10 + i], (i == 0) ? "R4 first write" : "R5 consecutive write",
                regs[8'h10 + i], exp_mem[8'h10 + i]);

        // R6 / R7 / R8: pointer write, repeated start, read four bytes
        start_cond();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h10, ack);
        start_cond();
        send_byte({DEV, 1'b1}, ack); chk(ack, "R8 ack after repeated start", ack, 1);
        for (int i = 0; i < 4; i++) begin
            recv_byte(i != 3, v);
            chk(v == exp_mem[8'h10 + i], "R6 read byte", v, exp_mem[8'h10 + i]);
        end
        for (int i = 0; i < 3; i++) begin
            recv_bit(b, h);
            chk(b == 1'b1, "R7 released after nack", b, 1);
        end
        stop_cond();

        // R6: pointer kept its advance (now 0x14)
        start_cond();
        send_byte({DEV, 1'b1}, ack);
        recv_byte(1'b0, v);
        stop_cond();
        chk(v == exp_mem[8'h14], "R6 pointer advanced", v, exp_mem[8'h14]);

        // R3: full transfer to a foreign address writes nothing
        w0 = wr_cnt;
        start_cond();
        send_byte({DEV ^ 7'h01, 1'b0}, ack); chk(!ack, "R3 foreign nack", ack, 0);
        send_byte(8'h20, ack);               chk(!ack, "R3 no ack on pointer", ack, 0);
        send_byte(8'h55, ack);               chk(!ack, "R3 no ack on data", ack, 0);
        stop_cond();
        chk(wr_cnt == w0, "R3 no write strobe", wr_cnt - w0, 0);
        chk(regs[8'h20] == exp_mem[8'h20], "R3 register untouched", regs[8'h20], exp_mem[8'h20]);

        // R1: bytes with no start after a stop
        w0 = wr_cnt;
        send_byte({DEV, 1'b0}, ack); chk(!ack, "R1 no ack without start", ack, 0);
        send_byte(8'h30, ack);       chk(!ack, "R1 idle data ignored", ack, 0);
        stop_cond();
        chk(wr_cnt == w0, "R1 no write without start", wr_cnt - w0, 0);

        // R8 / R10: repeated start mid-byte, then write across 0xFF
        start_cond();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        start_cond();
        send_byte({DEV, 1'b0}, ack); chk(ack, "R8 mid-byte restart ack", ack, 1);
        send_byte(8'hFF, ack);
        send_byte(8'h3C ^ {7'd0, mode}, ack); exp_mem[8'hFF] = 8'h3C ^ {7'd0, mode};
        send_byte(8'hC3, ack);                exp_mem[8'h00] = 8'hC3;
        chk(ack, "R10 ack after wrap", ack, 1);
        stop_cond();
        chk(regs[8'hFF] == exp_mem[8'hFF], "R10 write at 0xFF", regs[8'hFF], exp_mem[8'hFF]);
        chk(regs[8'h00] == exp_mem[8'h00], "R10 pointer wrap to 0x00", regs[8'h00], exp_mem[8'h00]);

        // R9: pin selection
        chk(wrong_pin == 0, "R9 wrong pin driven", wrong_pin, 0);
        chk(right_pin > 0, "R9 selected pin used", right_pin, 1);
    endtask

    initial begin
        run_mode(1'b0);
        run_mode(1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule